// File: doc/BRIEF.md
# Outbound Address Translation Unit

This block sits on the outgoing request path of a host bridge. It keeps a small number of translation windows. Each window maps a span of local addresses onto a target address and tags the request with a transaction type: memory, I/O, type-0 configuration or type-1 configuration. Software reaches the windows through an indirect viewport. A select register first picks a direction and a window number. Later accesses to the type, control, base, limit and target registers then act on that one window. The viewport lets a driver take the same physical window and point it at configuration space for one access, then back at memory or I/O space.

Each request address presented on `req_valid` is compared against every enabled window in parallel. One cycle later the block returns one of two results. On a hit it gives the translated address, the window number, the window's type code and, for configuration windows, the bus/device/function routing ID. On a miss it gives a miss flag with the address passed through unchanged.

Top module: `outbound_xlate`

## Requirements
- R1: After reset every window is disabled, the viewport register reads 0, every window register reads 0, and `rsp_valid` is low.
- R2: The viewport register is at offset 0x900. Bit 31 is the direction (1 = inbound, 0 = outbound) and bits IDX_FIELD_W-1:0 hold the window number. It reads back exactly those bits, with all other bits 0.
- R3: The type register is at 0x904 and holds a 3-bit code in bits 2:0: memory = 0, I/O = 2, type-0 configuration = 4, type-1 configuration = 5. It reads back in bits 2:0 with the upper bits 0.
- R4: The control register is at 0x908. Bit 31 enables the window. Bit 30 (base-address-register match mode) and all other bits are not kept and read 0.
- R5: The window registers sit at these offsets: lower base 0x90C, upper base 0x910, limit 0x914, lower target 0x918, upper target 0x91C. Each holds a full 32-bit word and reads back for the selected window.
- R6: While the viewport selects the inbound direction or a window number of NUM_REGIONS or more, writes to 0x904..0x91C change no window and reads of them return 0.
- R7: A window hits when it is enabled and {upper base, lower base} ≤ address ≤ {upper base, limit}. Both bounds are inclusive, and the limit holds the last address of the window.
- R8: A request accepted on a clock edge produces `rsp_valid` on the next cycle. On a hit, `rsp_addr` = {upper target, lower target} + (address − base), modulo 2^64.
- R9: When several windows hit, the lowest window number wins, and it is the one reported in `rsp_region`.
- R10: On a miss `rsp_hit` is 0, `rsp_addr` equals the request address, and `rsp_type`, `rsp_region` and `rsp_rid` are 0.
- R11: For a hit on a window of type 4 or 5, `rsp_rid` equals lower-target bits 31:16 (bus 31:24, device 23:19, function 18:16). For other types it is 0.
- R12: A request presented in the same cycle as a register write is translated with the register contents from before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 12 | Register offset for write and read |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Register read data for `cfg_addr` (combinational) |
| req_valid | input | 1 | Request address is valid |
| req_addr | input | 64 | Local request address |
| rsp_valid | output | 1 | Result valid, one cycle after `req_valid` |
| rsp_hit | output | 1 | Some enabled window matched |
| rsp_region | output | IDX_W | Number of the winning window |
| rsp_type | output | 3 | Transaction type code of the winning window |
| rsp_addr | output | 64 | Translated address, or request address on miss |
| rsp_rid | output | 16 | Bus/device/function routing ID for configuration hits |

## Verification
The assertions assume that the register strobe is a single write port, so a window can change only through the viewport-qualified write path. They also assume that `req_addr` is held alongside `req_valid`, so the pass-through check on a miss can compare against the previous cycle's address. The stimulus issues exactly one register write or one request, or one of each, per cycle, and drives all inputs on the falling edge. Window bounds are kept within one upper-base page, because the limit compares only the low word. Overlapping windows are set up on purpose to exercise priority.

// File: rtl/outbound_xlate_pkg.sv
package outbound_xlate_pkg;

  localparam int unsigned AW = 64;

  localparam logic [11:0] OFS_VIEW    = 12'h900;
  localparam logic [11:0] OFS_TYPE    = 12'h904;
  localparam logic [11:0] OFS_CTRL    = 12'h908;
  localparam logic [11:0] OFS_BASE_LO = 12'h90C;
  localparam logic [11:0] OFS_BASE_HI = 12'h910;
  localparam logic [11:0] OFS_LIMIT   = 12'h914;
  localparam logic [11:0] OFS_TGT_LO  = 12'h918;
  localparam logic [11:0] OFS_TGT_HI  = 12'h91C;

  localparam logic [2:0] TY_MEM  = 3'd0;
  localparam logic [2:0] TY_IO   = 3'd2;
  localparam logic [2:0] TY_CFG0 = 3'd4;
  localparam logic [2:0] TY_CFG1 = 3'd5;

  typedef struct packed {
    logic        en;
    logic [2:0]  ttype;
    logic [31:0] base_lo;
    logic [31:0] base_hi;
    logic [31:0] limit;
    logic [31:0] tgt_lo;
    logic [31:0] tgt_hi;
  } window_t;

  localparam int unsigned WIN_BITS = $bits(window_t);

  function automatic logic is_window_ofs(input logic [11:0] ofs);
    return (ofs >= OFS_TYPE) && (ofs <= OFS_TGT_HI) && (ofs[1:0] == 2'b00);
  endfunction

  function automatic logic in_window(input window_t w, input logic [AW-1:0] a);
    return w.en && (a >= {w.base_hi, w.base_lo}) && (a <= {w.base_hi, w.limit});
  endfunction

  function automatic logic [AW-1:0] xlate(input window_t w, input logic [AW-1:0] a);
    return {w.tgt_hi, w.tgt_lo} + (a - {w.base_hi, w.base_lo});
  endfunction

  function automatic logic [15:0] route_id(input window_t w);
    return ((w.ttype == TY_CFG0) || (w.ttype == TY_CFG1)) ? w.tgt_lo[31:16] : 16'h0;
  endfunction

endpackage

// File: rtl/oxl_window.sv
module oxl_window
  import outbound_xlate_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [11:0]   wr_ofs,
  input  logic [31:0]   wr_data,
  input  logic [AW-1:0] look_addr,
  output window_t       state,
  output logic          hit,
  output logic [AW-1:0] xaddr
);

  window_t w_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      w_q <= '0;
    end else if (wr_en) begin
      case (wr_ofs)
        OFS_TYPE:    w_q.ttype   <= wr_data[2:0];
        OFS_CTRL:    w_q.en      <= wr_data[31];
        OFS_BASE_LO: w_q.base_lo <= wr_data;
        OFS_BASE_HI: w_q.base_hi <= wr_data;
        OFS_LIMIT:   w_q.limit   <= wr_data;
        OFS_TGT_LO:  w_q.tgt_lo  <= wr_data;
        OFS_TGT_HI:  w_q.tgt_hi  <= wr_data;
        default:     w_q         <= w_q;
      endcase
    end
  end

  assign state = w_q;
  assign hit   = in_window(w_q, look_addr);
  assign xaddr = xlate(w_q, look_addr);

endmodule

// File: rtl/oxl_prio.sv
module oxl_prio #(
  parameter int unsigned N     = 2,
  parameter int unsigned IDX_W = 1
) (
  input  logic [N-1:0]     hit_vec,
  output logic             found,
  output logic [IDX_W-1:0] idx
);

  always_comb begin
    found = 1'b0;
    idx   = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (hit_vec[i]) begin
        found = 1'b1;
        idx   = IDX_W'(i);
      end
    end
  end

endmodule

// File: rtl/outbound_xlate.sv
module outbound_xlate
  import outbound_xlate_pkg::*;
#(
  parameter int unsigned NUM_REGIONS = 2,
  parameter int unsigned IDX_FIELD_W = 4,
  localparam int unsigned IDX_W = (NUM_REGIONS > 1) ? $clog2(NUM_REGIONS) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic [11:0]      cfg_addr,
  input  logic [31:0]      cfg_wdata,
  output logic [31:0]      cfg_rdata,
  input  logic             req_valid,
  input  logic [63:0]      req_addr,
  output logic             rsp_valid,
  output logic             rsp_hit,
  output logic [IDX_W-1:0] rsp_region,
  output logic [2:0]       rsp_type,
  output logic [63:0]      rsp_addr,
  output logic [15:0]      rsp_rid
);

  // viewport
  logic                   vp_dir_q;
  logic [IDX_FIELD_W-1:0] vp_idx_q;
  logic                   vp_ok;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vp_dir_q <= 1'b0;
      vp_idx_q <= '0;
    end else if (cfg_we && (cfg_addr == OFS_VIEW)) begin
      vp_dir_q <= cfg_wdata[31];
      vp_idx_q <= cfg_wdata[IDX_FIELD_W-1:0];
    end
  end

  assign vp_ok = !vp_dir_q && (int'(vp_idx_q) < int'(NUM_REGIONS));

  // named events for the checker
  logic                           win_wr;
  logic                           blk_wr;
  window_t [NUM_REGIONS-1:0]      wins;
  logic    [NUM_REGIONS-1:0]      hit_vec;
  logic    [AW-1:0]               xaddr [NUM_REGIONS];
  logic                           win_found;
  logic    [IDX_W-1:0]            win_idx;
  logic [NUM_REGIONS*WIN_BITS-1:0] wins_flat;

  assign win_wr    = cfg_we && is_window_ofs(cfg_addr);
  assign blk_wr    = win_wr && !vp_ok;
  assign wins_flat = wins;

  for (genvar g = 0; g < NUM_REGIONS; g++) begin : g_win
    oxl_window u_win (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_en     (win_wr && vp_ok && (vp_idx_q == IDX_FIELD_W'(g))),
      .wr_ofs    (cfg_addr),
      .wr_data   (cfg_wdata),
      .look_addr (req_addr),
      .state     (wins[g]),
      .hit       (hit_vec[g]),
      .xaddr     (xaddr[g])
    );
  end

  oxl_prio #(.N(NUM_REGIONS), .IDX_W(IDX_W)) u_prio (
    .hit_vec (hit_vec),
    .found   (win_found),
    .idx     (win_idx)
  );

  // register read path
  window_t sel_w;

  always_comb begin
    sel_w = '0;
    for (int i = 0; i < NUM_REGIONS; i++) begin
      if (vp_ok && (vp_idx_q == IDX_FIELD_W'(i))) sel_w = wins[i];
    end
    case (cfg_addr)
      OFS_VIEW:    cfg_rdata = {vp_dir_q, {(31-IDX_FIELD_W){1'b0}}, vp_idx_q};
      OFS_TYPE:    cfg_rdata = {29'b0, sel_w.ttype};
      OFS_CTRL:    cfg_rdata = {sel_w.en, 31'b0};
      OFS_BASE_LO: cfg_rdata = sel_w.base_lo;
      OFS_BASE_HI: cfg_rdata = sel_w.base_hi;
      OFS_LIMIT:   cfg_rdata = sel_w.limit;
      OFS_TGT_LO:  cfg_rdata = sel_w.tgt_lo;
      OFS_TGT_HI:  cfg_rdata = sel_w.tgt_hi;
      default:     cfg_rdata = 32'h0;
    endcase
  end

  // winner data
  window_t         win_w;
  logic [AW-1:0]   win_xaddr;

  always_comb begin
    win_w     = '0;
    win_xaddr = '0;
    for (int i = 0; i < NUM_REGIONS; i++) begin
      if (win_idx == IDX_W'(i)) begin
        win_w     = wins[i];
        win_xaddr = xaddr[i];
      end
    end
  end

  // response stage
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid  <= 1'b0;
      rsp_hit    <= 1'b0;
      rsp_region <= '0;
      rsp_type   <= '0;
      rsp_addr   <= '0;
      rsp_rid    <= '0;
    end else begin
      rsp_valid <= req_valid;
      if (req_valid) begin
        rsp_hit    <= win_found;
        rsp_region <= win_found ? win_idx : '0;
        rsp_type   <= win_found ? win_w.ttype : TY_MEM;
        rsp_addr   <= win_found ? win_xaddr : req_addr;
        rsp_rid    <= win_found ? route_id(win_w) : 16'h0;
      end
    end
  end

endmodule

// File: rtl/outbound_xlate_chk.sv
module outbound_xlate_chk
  import outbound_xlate_pkg::*;
#(
  parameter int unsigned NUM_REGIONS = 2,
  parameter int unsigned IDX_W       = 1
) (
  input logic                            clk,
  input logic                            rst_n,
  input logic                            req_valid,
  input logic [63:0]                     req_addr,
  input logic                            rsp_valid,
  input logic                            rsp_hit,
  input logic [IDX_W-1:0]                rsp_region,
  input logic [2:0]                      rsp_type,
  input logic [63:0]                     rsp_addr,
  input logic [15:0]                     rsp_rid,
  input logic [11:0]                     cfg_addr,
  input logic [31:0]                     cfg_rdata,
  input logic                            blk_wr,
  input logic [NUM_REGIONS*WIN_BITS-1:0] wins_flat,
  input logic [NUM_REGIONS-1:0]          hit_vec,
  input logic                            win_found,
  input logic [IDX_W-1:0]                win_idx
);

  logic [NUM_REGIONS-1:0] below_mask;
  always_comb begin
    below_mask = '0;
    for (int i = 0; i < NUM_REGIONS; i++) begin
      if (IDX_W'(i) < win_idx) below_mask[i] = 1'b1;
    end
  end

  p_reset_idle_r1: assert property (@(posedge clk) !rst_n |=> !rsp_valid);

  p_ctrl_only_en_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_addr == OFS_CTRL) |-> (cfg_rdata[30:0] == 31'h0));

  p_blocked_wr_r6: assert property (@(posedge clk) disable iff (!rst_n)
    blk_wr |=> $stable(wins_flat));

  p_latency_r8: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid);

  p_no_spurious_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !rsp_valid);

  p_lowest_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
    win_found |-> (hit_vec[win_idx] && ((hit_vec & below_mask) == '0)));

  p_region_match_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && win_found) |=> (rsp_hit && (rsp_region == $past(win_idx))));

  p_miss_passthru_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_hit) |-> ((rsp_addr == $past(req_addr)) && (rsp_type == 3'd0)
                                  && (rsp_rid == 16'h0) && (rsp_region == '0)));

  p_rid_zero_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_hit && (rsp_type != TY_CFG0) && (rsp_type != TY_CFG1))
      |-> (rsp_rid == 16'h0));

endmodule

bind outbound_xlate outbound_xlate_chk #(
  .NUM_REGIONS (NUM_REGIONS),
  .IDX_W       (IDX_W)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .req_valid  (req_valid),
  .req_addr   (req_addr),
  .rsp_valid  (rsp_valid),
  .rsp_hit    (rsp_hit),
  .rsp_region (rsp_region),
  .rsp_type   (rsp_type),
  .rsp_addr   (rsp_addr),
  .rsp_rid    (rsp_rid),
  .cfg_addr   (cfg_addr),
  .cfg_rdata  (cfg_rdata),
  .blk_wr     (blk_wr),
  .wins_flat  (wins_flat),
  .hit_vec    (hit_vec),
  .win_found  (win_found),
  .win_idx    (win_idx)
);

// File: tb/outbound_xlate_tb.sv
module outbound_xlate_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [11:0] cfg_addr = 12'h0;
  logic [31:0] cfg_wdata = 32'h0;
  logic [31:0] cfg_rdata;
  logic        req_valid = 1'b0;
  logic [63:0] req_addr = 64'h0;
  logic        rsp_valid, rsp_hit;
  logic [0:0]  rsp_region;
  logic [2:0]  rsp_type;
  logic [63:0] rsp_addr;
  logic [15:0] rsp_rid;

  always #4 clk = ~clk;

  outbound_xlate u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .req_valid(req_valid),
    .req_addr(req_addr), .rsp_valid(rsp_valid), .rsp_hit(rsp_hit),
    .rsp_region(rsp_region), .rsp_type(rsp_type), .rsp_addr(rsp_addr),
    .rsp_rid(rsp_rid)
  );

  int n_vec = 0;
  int n_bad = 0;
  bit finished = 0;

  // bench-side model of the programmed state
  bit          m_dir;
  logic [3:0]  m_idx;
  bit          m_en  [2];
  logic [2:0]  m_ty  [2];
  logic [31:0] m_blo [2], m_bhi [2], m_lim [2], m_tlo [2], m_thi [2];

  typedef struct {
    bit          hit;
    logic [0:0]  reg_n;
    logic [2:0]  ty;
    logic [63:0] addr;
    logic [15:0] rid;
    string       tag;
  } exp_t;

  exp_t sb[$];

  function automatic void model_wr(input logic [11:0] a, input logic [31:0] d);
    int k;
    if (a == 12'h900) begin
      m_dir = d[31];
      m_idx = d[3:0];
      return;
    end
    if (m_dir || m_idx > 4'd1) return;            // R6: blocked
    k = int'(m_idx);
    case (a)
      12'h904: m_ty[k]  = d[2:0];
      12'h908: m_en[k]  = d[31];
      12'h90C: m_blo[k] = d;
      12'h910: m_bhi[k] = d;
      12'h914: m_lim[k] = d;
      12'h918: m_tlo[k] = d;
      12'h91C: m_thi[k] = d;
      default: ;
    endcase
  endfunction

  function automatic exp_t model_look(input logic [63:0] a, input string tag);
    exp_t e;
    e.hit = 0; e.reg_n = '0; e.ty = 3'd0; e.addr = a; e.rid = 16'h0; e.tag = tag;
    for (int k = 1; k >= 0; k--) begin
      logic [63:0] lo, hi;
      lo = {m_bhi[k], m_blo[k]};
      hi = {m_bhi[k], m_lim[k]};
      if (m_en[k] && !(a < lo) && !(a > hi)) begin
        e.hit   = 1;
        e.reg_n = 1'(k);
        e.ty    = m_ty[k];
        e.addr  = a + ({m_thi[k], m_tlo[k]} - lo);
        e.rid   = (m_ty[k] == 3'd4 || m_ty[k] == 3'd5) ? m_tlo[k][31:16] : 16'h0;
      end
    end
    return e;
  endfunction

  // one cycle: optional write, optional request
  task automatic step(input bit do_wr, input logic [11:0] a, input logic [31:0] d,
                      input bit do_req, input logic [63:0] ra, input string tag);
    @(negedge clk);
    if (do_req) sb.push_back(model_look(ra, tag));  // R12: before same-cycle write
    cfg_we = do_wr; cfg_addr = a; cfg_wdata = d;
    req_valid = do_req; req_addr = ra;
    if (do_wr) model_wr(a, d);
    @(negedge clk);
    cfg_we = 1'b0;
    req_valid = 1'b0;
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    step(1, a, d, 0, 64'h0, "");
  endtask

  task automatic look(input logic [63:0] ra, input string tag);
    step(0, 12'h0, 32'h0, 1, ra, tag);
  endtask

  task automatic rd_chk(input logic [11:0] a, input logic [31:0] exp_v, input string tag);
    @(negedge clk);
    cfg_we = 1'b0;
    cfg_addr = a;
    #1;
    n_vec++;
    if (cfg_rdata !== exp_v) begin
      n_bad++;
      $display("FAIL %s read 0x%03h: got %08h expected %08h", tag, a, cfg_rdata, exp_v);
    end
  endtask

  // monitor
  always @(negedge clk) begin
    if (rst_n && rsp_valid) begin
      exp_t e;
      n_vec++;
      if (sb.size() == 0) begin
        n_bad++;
        $display("FAIL R8 unexpected response: got addr %016h expected none", rsp_addr);
      end else begin
        e = sb.pop_front();
        if (rsp_hit !== e.hit || rsp_region !== e.reg_n || rsp_type !== e.ty ||
            rsp_addr !== e.addr || rsp_rid !== e.rid) begin
          n_bad++;
          $display("FAIL %s: got hit=%0b reg=%0d ty=%0d addr=%016h rid=%04h expected hit=%0b reg=%0d ty=%0d addr=%016h rid=%04h",
                   e.tag, rsp_hit, rsp_region, rsp_type, rsp_addr, rsp_rid,
                   e.hit, e.reg_n, e.ty, e.addr, e.rid);
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_vec++;
      n_bad++;
      $display("FAIL watchdog: got no completion expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    m_dir = 0; m_idx = 0;
    for (int k = 0; k < 2; k++) begin
      m_en[k] = 0; m_ty[k] = 0; m_blo[k] = 0; m_bhi[k] = 0;
      m_lim[k] = 0; m_tlo[k] = 0; m_thi[k] = 0;
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    n_vec++;
    if (rsp_valid !== 1'b0) begin
      n_bad++;
      $display("FAIL R1 rsp_valid: got %0b expected 0", rsp_valid);
    end

    // R1 reset state
    rd_chk(12'h900, 32'h0, "R1");
    rd_chk(12'h904, 32'h0, "R1");
    rd_chk(12'h908, 32'h0, "R1");
    rd_chk(12'h914, 32'h0, "R1");
    look(64'h0000_0001_2345_6789, "R1 R10 miss after reset");

    // window 0: memory
    wr(12'h900, 32'h0000_0000);
    wr(12'h904, 32'h0000_0000);
    wr(12'h90C, 32'h2000_0000);
    wr(12'h910, 32'h0000_0001);
    wr(12'h914, 32'h2FFF_FFFF);
    wr(12'h918, 32'h8000_0000);
    wr(12'h91C, 32'h0000_0000);
    wr(12'h908, 32'hC000_0000);
    rd_chk(12'h908, 32'h8000_0000, "R4 bar bit dropped");
    rd_chk(12'h90C, 32'h2000_0000, "R5");
    rd_chk(12'h910, 32'h0000_0001, "R5");
    rd_chk(12'h914, 32'h2FFF_FFFF, "R5");
    rd_chk(12'h918, 32'h8000_0000, "R5");
    rd_chk(12'h904, 32'h0, "R3");

    look(64'h0000_0001_2000_0000, "R7 base edge");
    look(64'h0000_0001_2FFF_FFFF, "R7 limit edge");
    look(64'h0000_0001_3000_0000, "R7 limit+1");
    look(64'h0000_0001_1FFF_FFFF, "R7 base-1");
    look(64'h0000_0002_2400_0000, "R7 upper word differs");
    look(64'h0000_0001_2468_ACE0, "R8 mid offset");

    // window 1: type-1 config overlapping window 0
    wr(12'h900, 32'h0000_0001);
    wr(12'h904, 32'h0000_0005);
    wr(12'h90C, 32'h2800_0000);
    wr(12'h910, 32'h0000_0001);
    wr(12'h914, 32'h28FF_FFFF);
    wr(12'h918, 32'h033A_0000);               // bus 3, dev 7, fn 2
    wr(12'h91C, 32'h0000_0000);
    wr(12'h908, 32'h8000_0000);
    rd_chk(12'h904, 32'h0000_0005, "R3");
    rd_chk(12'h900, 32'h0000_0001, "R2");
    look(64'h0000_0001_2800_0104, "R9 overlap lowest wins");

    // disable window 0, window 1 takes over
    wr(12'h900, 32'h0000_0000);
    wr(12'h908, 32'h0000_0000);
    look(64'h0000_0001_2800_0104, "R11 config rid");
    look(64'h0000_0001_2900_0000, "R10 miss past window 1");

    // R6 inbound and out-of-range selections
    wr(12'h900, 32'h8000_0001);
    rd_chk(12'h900, 32'h8000_0001, "R2 inbound select");
    wr(12'h904, 32'h0000_0002);
    wr(12'h908, 32'h0000_0000);
    rd_chk(12'h904, 32'h0, "R6 inbound read");
    wr(12'h900, 32'h0000_0003);
    rd_chk(12'h900, 32'h0000_0003, "R2");
    wr(12'h914, 32'h0000_0000);
    rd_chk(12'h914, 32'h0, "R6 out of range read");
    wr(12'h900, 32'h0000_0001);
    rd_chk(12'h904, 32'h0000_0005, "R6 type untouched");
    rd_chk(12'h914, 32'h28FF_FFFF, "R6 limit untouched");
    look(64'h0000_0001_2800_0010, "R6 window 1 still enabled");

    // R12 same-cycle disable and request
    step(1, 12'h908, 32'h0, 1, 64'h0000_0001_2800_0020, "R12 old state used");
    look(64'h0000_0001_2800_0020, "R12 new state after write");

    // window 0 as I/O with wrapping target
    wr(12'h900, 32'h0000_0000);
    wr(12'h904, 32'h0000_0002);
    wr(12'h918, 32'hFFFF_FF00);
    wr(12'h91C, 32'hFFFF_FFFF);
    wr(12'h908, 32'h8000_0000);
    look(64'h0000_0001_2000_0200, "R8 R11 wrap io");

    // window 0 as type-0 config
    wr(12'h904, 32'h0000_0004);
    wr(12'h918, 32'h0108_0000);
    wr(12'h91C, 32'h0000_0000);
    look(64'h0000_0001_2000_0040, "R11 cfg0 rid");

    repeat (3) @(negedge clk);
    n_vec++;
    if (sb.size() != 0) begin
      n_bad++;
      $display("FAIL R8 missing responses: got %0d pending expected 0", sb.size());
    end
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule